// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the software-visible control store of an audio codec. A bus master reaches sixteen 32-bit direct words, decoded from a 64-byte window with byte address bits [5:2]. Behind the direct words sits a bank of thirty-two 8-bit indirect registers. Software selects one of them by writing an index into direct word 0. It then reads or writes that register through the data window at direct word 1.

The indirect registers follow per-index rules. One index can be written but always reads as zero. Two indices are read-only and hold identification values. One index holds a codec version pattern and has a single writable bit. Direct word 2 cannot be written. Direct word 4 is a 7-bit control word. Writing it with bit 0 set returns both banks to their reset contents in one cycle, and the control word then keeps the written value. Reads return data one cycle after the read strobe.

Top module: `cdc_ctrl_regfile`

## Requirements
- R1: After the hardware reset, every direct word reads 0. Every indirect register reads 0, except index 12, which reads 0x8A, and index 25, which reads 0xA0.
- R2: The direct word is selected by address bits [5:2], and bits [1:0] are ignored. A write to any word other than 1, 2 or 4 stores all 32 bits, which read back unchanged.
- R3: The active index is bits [4:0] of direct word 0. A read of word 1 returns the indexed register zero-extended to 32 bits. A write to word 1 stores wdata[7:0] there.
- R4: A read through word 1 at index 3 returns 0, whatever was written there.
- R5: Writes through word 1 at index 11 or 25 leave the register unchanged.
- R6: A write through word 1 at index 12 stores (wdata & 0x40) | 0x8A.
- R7: Writes to direct word 2 are ignored, so it always reads 0.
- R8: A write to direct word 4 stores wdata[6:0], and bits [31:7] read 0.
- R9: A write to direct word 4 with wdata[0] = 1 restores every register to its R1 value in the same cycle. Word 4 then holds wdata[6:0].
- R10: When bus_sel is high and bus_wr is low at a clock edge, bus_rdata holds the addressed value after that edge and bus_rvalid is high for exactly that one cycle. At all other times bus_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
Full 32-bit patterns written to plain direct words confirm that writes store every bit. The same patterns sent through the data window at ordinary indices show the truncation to 8 bits. Moving the index across its range, and writing index values with high bits set, separates correct 5-bit index decoding from aliasing. All-ones and all-zeros written at the version index, the read-only indices and the write-only index show whether each rule masks, blocks or hides the data. A soft reset issued after the banks have been filled with non-zero data shows that the reset and the masked control write are applied in the right order.

// File: rtl/cdc_regs_pkg.sv
package cdc_regs_pkg;
  localparam int unsigned DIR_WORDS = 16;
  localparam int unsigned DIR_W     = 32;
  localparam int unsigned IND_REGS  = 32;
  localparam int unsigned IND_W     = 8;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned WORD_AW   = $clog2(DIR_WORDS);
  localparam int unsigned IND_AW    = $clog2(IND_REGS);
  localparam int unsigned CTRL_BITS = 7;

  // direct word roles
  localparam int unsigned W_INDEX  = 0;
  localparam int unsigned W_WINDOW = 1;
  localparam int unsigned W_LOCKED = 2;
  localparam int unsigned W_CTRL   = 4;

  // indirect index roles
  localparam int unsigned IX_HIDDEN = 3;
  localparam int unsigned IX_RO_A   = 11;
  localparam int unsigned IX_VER    = 12;
  localparam int unsigned IX_RO_B   = 25;

  localparam logic [IND_W-1:0] CODEC_VER = 8'h8A;
  localparam logic [IND_W-1:0] CHIP_ID   = 8'hA0;
  localparam logic [IND_W-1:0] VER_OPEN  = 8'h40;

  function automatic logic [WORD_AW-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  function automatic logic [IND_W-1:0] ind_reset_value(input int unsigned ix);
    if (ix == IX_VER)  return CODEC_VER;
    if (ix == IX_RO_B) return CHIP_ID;
    return '0;
  endfunction

  function automatic logic ind_is_locked(input int unsigned ix);
    return (ix == IX_RO_A) || (ix == IX_RO_B);
  endfunction

  function automatic logic [IND_W-1:0] ind_merge(input int unsigned ix,
                                                 input logic [IND_W-1:0] d);
    if (ix == IX_VER) return (d & VER_OPEN) | CODEC_VER;
    return d;
  endfunction

  function automatic logic [IND_W-1:0] ind_read_view(input logic [IND_AW-1:0] ix,
                                                     input logic [IND_W-1:0] v);
    return (ix == IND_AW'(IX_HIDDEN)) ? '0 : v;
  endfunction

  function automatic logic [DIR_W-1:0] ctrl_mask(input logic [DIR_W-1:0] d);
    return {{(DIR_W-CTRL_BITS){1'b0}}, d[CTRL_BITS-1:0]};
  endfunction
endpackage

// File: rtl/cdc_bus_decode.sv
module cdc_bus_decode
  import cdc_regs_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned WAW = WORD_AW
) (
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic           wdata_lsb,
  output logic           rd_req,
  output logic           wr_req,
  output logic [WAW-1:0] word,
  output logic           win_wr,
  output logic           ctrl_wr,
  output logic           soft_rst
);
  always_comb begin
    word     = word_of(bus_addr);
    rd_req   = bus_sel && !bus_wr;
    wr_req   = bus_sel && bus_wr;
    win_wr   = wr_req && (word == WAW'(W_WINDOW));
    ctrl_wr  = wr_req && (word == WAW'(W_CTRL));
    soft_rst = ctrl_wr && wdata_lsb;
  end
endmodule

// File: rtl/cdc_direct_bank.sv
module cdc_direct_bank
  import cdc_regs_pkg::*;
#(
  parameter int unsigned WORDS = DIR_WORDS,
  parameter int unsigned W     = DIR_W,
  localparam int unsigned WAW  = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [WAW-1:0]        word,
  input  logic [W-1:0]          wdata,
  input  logic                  soft_rst,
  output logic [WORDS-1:0][W-1:0] regs_q
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == W_WINDOW || g == W_LOCKED) begin : g_nostore
      assign regs_q[g] = '0;
    end else if (g == W_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             regs_q[g] <= '0;
        else if (wr_req && word == WAW'(g))     regs_q[g] <= ctrl_mask(wdata);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             regs_q[g] <= '0;
        else if (soft_rst)                      regs_q[g] <= '0;
        else if (wr_req && word == WAW'(g))     regs_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cdc_indirect_bank.sv
module cdc_indirect_bank
  import cdc_regs_pkg::*;
#(
  parameter int unsigned REGS = IND_REGS,
  parameter int unsigned W    = IND_W,
  localparam int unsigned IAW = $clog2(REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_wr,
  input  logic [IAW-1:0]       idx,
  input  logic [W-1:0]         wdata,
  input  logic                 soft_rst,
  output logic [REGS-1:0][W-1:0] regs_q,
  output logic [W-1:0]         rd_view,
  output logic                 wr_blocked
);
  for (genvar g = 0; g < REGS; g++) begin : g_ent
    if (ind_is_locked(g)) begin : g_locked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        regs_q[g] <= ind_reset_value(g);
        else if (soft_rst) regs_q[g] <= ind_reset_value(g);
      end
    end else begin : g_open
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          regs_q[g] <= ind_reset_value(g);
        else if (soft_rst)                   regs_q[g] <= ind_reset_value(g);
        else if (win_wr && idx == IAW'(g))   regs_q[g] <= ind_merge(g, wdata);
      end
    end
  end

  always_comb begin
    rd_view    = ind_read_view(idx, regs_q[idx]);
    wr_blocked = win_wr && (idx == IAW'(IX_RO_A) || idx == IAW'(IX_RO_B));
  end
endmodule

// File: rtl/cdc_ctrl_regfile.sv
module cdc_ctrl_regfile
  import cdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIR_W-1:0]  bus_wdata,
  output logic [DIR_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic                          rd_req, wr_req, win_wr, ctrl_wr, soft_rst_evt;
  logic [WORD_AW-1:0]            word;
  logic [DIR_WORDS-1:0][DIR_W-1:0] dir_q;
  logic [IND_REGS-1:0][IND_W-1:0]  ind_q;
  logic [IND_W-1:0]              ind_view;
  logic                          ro_wr_evt;
  logic [IND_AW-1:0]             cur_idx;
  logic [IND_W-1:0]              ind_v12, ind_v25;
  logic [DIR_W-1:0]              dir0, dir4;

  cdc_bus_decode #(.AW(ADDR_W), .WAW(WORD_AW)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wdata_lsb(bus_wdata[0]), .rd_req(rd_req), .wr_req(wr_req),
    .word(word), .win_wr(win_wr), .ctrl_wr(ctrl_wr), .soft_rst(soft_rst_evt)
  );

  cdc_direct_bank #(.WORDS(DIR_WORDS), .W(DIR_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .word(word),
    .wdata(bus_wdata), .soft_rst(soft_rst_evt), .regs_q(dir_q)
  );

  assign cur_idx = dir_q[W_INDEX][IND_AW-1:0];

  cdc_indirect_bank #(.REGS(IND_REGS), .W(IND_W)) u_ind (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .idx(cur_idx),
    .wdata(bus_wdata[IND_W-1:0]), .soft_rst(soft_rst_evt),
    .regs_q(ind_q), .rd_view(ind_view), .wr_blocked(ro_wr_evt)
  );

  // named views for the checker
  assign ind_v12 = ind_q[IX_VER];
  assign ind_v25 = ind_q[IX_RO_B];
  assign dir0    = dir_q[W_INDEX];
  assign dir4    = dir_q[W_CTRL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req)
        bus_rdata <= (word == WORD_AW'(W_WINDOW))
                     ? {{(DIR_W-IND_W){1'b0}}, ind_view} : dir_q[word];
    end
  end
endmodule

// File: rtl/cdc_ctrl_regfile_chk.sv
module cdc_ctrl_regfile_chk
  import cdc_regs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_req,
  input logic               ctrl_wr,
  input logic               soft_rst_evt,
  input logic               ro_wr_evt,
  input logic [WORD_AW-1:0] word,
  input logic [IND_AW-1:0]  cur_idx,
  input logic [DIR_W-1:0]   wdata,
  input logic [IND_W-1:0]   ind_view,
  input logic [IND_W-1:0]   ind_v12,
  input logic [IND_W-1:0]   ind_v25,
  input logic [DIR_W-1:0]   dir0,
  input logic [DIR_W-1:0]   dir4,
  input logic [DIR_W-1:0]   rdata,
  input logic               rvalid
);
  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid);
  // R5
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr_evt |=> $stable(ind_view));
  // R6
  ver_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_v12 & 8'hBF) == CODEC_VER);
  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> (dir0 == '0) && (ind_v25 == CHIP_ID) && (ind_v12 == CODEC_VER)
                     && (dir4[CTRL_BITS-1:0] == $past(wdata[CTRL_BITS-1:0])));
  // R8
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> dir4[DIR_W-1:CTRL_BITS] == '0);
  // R4
  hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && word == WORD_AW'(W_WINDOW) && cur_idx == IND_AW'(IX_HIDDEN)) |=> rdata == '0);
endmodule

bind cdc_ctrl_regfile cdc_ctrl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .ctrl_wr(ctrl_wr),
  .soft_rst_evt(soft_rst_evt), .ro_wr_evt(ro_wr_evt), .word(word),
  .cur_idx(cur_idx), .wdata(bus_wdata), .ind_view(ind_view),
  .ind_v12(ind_v12), .ind_v25(ind_v25), .dir0(dir0), .dir4(dir4),
  .rdata(bus_rdata), .rvalid(bus_rvalid)
);

// File: tb/cdc_ctrl_regfile_tb.sv
module cdc_ctrl_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdc_ctrl_regfile u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
    if (bus_rvalid !== 1'b1) begin checks++; fails++;
      $display("FAIL R10: actual rvalid %b expected 1", bus_rvalid); end
  endtask

  task automatic ind_wr(int ix, logic [31:0] d);
    wr(6'h00, ix); wr(6'h04, d);
  endtask

  task automatic ind_rd(int ix, output logic [31:0] d);
    wr(6'h00, ix); rd(6'h04, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 rvalid idle", {31'b0, bus_rvalid}, 0);
    for (int w = 0; w < 16; w++) begin
      if (w == 1) continue;
      rd(6'(w*4), v); check("R1 direct", v, 0);
    end
    ind_rd(0, v);  check("R1 ind0", v, 0);
    ind_rd(12, v); check("R1 ind12", v, 32'h8A);
    ind_rd(25, v); check("R1 ind25", v, 32'hA0);
    ind_rd(31, v); check("R1 ind31", v, 0);
  endtask

  task automatic t_direct;
    logic [31:0] v;
    wr(6'h14, 32'hDEADBEEF); rd(6'h14, v); check("R2 word5", v, 32'hDEADBEEF);
    wr(6'h1B, 32'h12345678); rd(6'h18, v); check("R2 low addr bits", v, 32'h12345678);
    wr(6'h3C, 32'hFFFFFFFF); rd(6'h3D, v); check("R2 word15", v, 32'hFFFFFFFF);
    rd(6'h14, v); check("R2 word5 kept", v, 32'hDEADBEEF);
  endtask

  task automatic t_indirect;
    logic [31:0] v;
    ind_wr(0, 32'h1A5);  ind_rd(0, v);  check("R3 ind0 trunc", v, 32'hA5);
    ind_wr(7, 32'h33);   ind_rd(7, v);  check("R3 ind7", v, 32'h33);
    ind_wr(31, 32'hC3);  ind_rd(31, v); check("R3 ind31", v, 32'hC3);
    wr(6'h00, 32'hFFFFFFE7); rd(6'h04, v); check("R3 index low bits", v, 32'h33);
    ind_rd(0, v); check("R3 ind0 kept", v, 32'hA5);
  endtask

  task automatic t_hidden;
    logic [31:0] v;
    ind_wr(3, 32'h55); ind_rd(3, v); check("R4 ind3 reads zero", v, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    ind_wr(11, 32'hFF); ind_rd(11, v); check("R5 ind11", v, 0);
    ind_wr(25, 32'h00); ind_rd(25, v); check("R5 ind25", v, 32'hA0);
  endtask

  task automatic t_version;
    logic [31:0] v;
    ind_wr(12, 32'hFF); ind_rd(12, v); check("R6 ver ones", v, 32'hCA);
    ind_wr(12, 32'h00); ind_rd(12, v); check("R6 ver zeros", v, 32'h8A);
    ind_wr(12, 32'h40); ind_rd(12, v); check("R6 ver bit6", v, 32'hCA);
  endtask

  task automatic t_locked_word;
    logic [31:0] v;
    wr(6'h08, 32'hCAFEF00D); rd(6'h08, v); check("R7 word2", v, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(6'h10, 32'hFFFFFFFE); rd(6'h10, v); check("R8 ctrl mask", v, 32'h7E);
    rd(6'h14, v); check("R8 no reset bit0=0", v, 32'hDEADBEEF);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    ind_wr(7, 32'h33);
    wr(6'h00, 32'h7);
    wr(6'h10, 32'h000000C3);
    rd(6'h10, v); check("R9 ctrl after reset", v, 32'h43);
    rd(6'h00, v); check("R9 index cleared", v, 0);
    rd(6'h14, v); check("R9 word5 cleared", v, 0);
    rd(6'h04, v); check("R9 ind0 cleared", v, 0);
    ind_rd(7, v);  check("R9 ind7 cleared", v, 0);
    ind_rd(12, v); check("R9 ind12 reload", v, 32'h8A);
    ind_rd(25, v); check("R9 ind25 reload", v, 32'hA0);
  endtask

  task automatic t_rvalid;
    logic [31:0] v;
    rd(6'h10, v);
    @(negedge clk); check("R10 rvalid single", {31'b0, bus_rvalid}, 0);
    check("R10 rdata held", bus_rdata, 32'h43);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_hidden();
    t_readonly();
    t_version();
    t_locked_word();
    t_ctrl();
    t_soft_reset();
    t_rvalid();
    done = 1;
    finish_run();
  end
endmodule